// File: doc/BRIEF.md
# Condition-Code ALU with Branch Evaluator

This block is the integer execute stage of a small 32-bit machine. It takes two operands, a source `srcA` and a destination `srcB`, and a 4-bit operation code. It returns one of four results: the sum, the difference destination minus source, the bitwise AND, or the bitwise exclusive-OR. The result is combinational and belongs in the destination operand's slot. Three condition flags sit in a small register: overflow, zero and negative. That register is written only on a clock edge where an operation is enabled and its code is valid.

A second code input selects a jump condition. The block evaluates it against the stored flags, so a branch sees the flags left by the last enabled operation. Unknown operation codes and unknown jump codes each raise their own invalid indicator. An unknown operation never disturbs the flags, and an unknown jump code never reports a taken branch.

Top module: `cond_alu`

## Requirements
- R1: Operation code 0 gives srcB+srcA, 1 gives srcB−srcA, 2 gives srcB AND srcA and 3 gives srcB XOR srcA. All results are modulo 2^WIDTH and appear on `result` in the same cycle.
- R2: The flag register loads only on a rising clock edge where `opEn` is high and the operation code is 0 to 3. On every other edge it keeps its value.
- R3: A flag load sets the zero flag when the result is all zeros, and sets the negative flag to the result's most significant bit.
- R4: A flag load sets the overflow flag as follows. For code 0 it is set on two's-complement signed overflow of the sum. For code 1 it is set on signed overflow of srcB−srcA. For codes 2 and 3 it is cleared.
- R5: While `rstN` is low, the flags are zero=1, negative=0 and overflow=0.
- R6: The jump codes and the conditions they take, evaluated combinationally from the stored flags (L denotes negative XOR overflow):
  - 0: always taken.
  - 1: L OR zero.
  - 2: L.
  - 3: zero.
  - 4: NOT zero.
  - 5: NOT L.
  - 6: NOT L AND NOT zero.
- R7: Operation codes 4 to 15 raise `aluFuncBad` and drive `result` to 0. With such a code, `opEn` has no effect on the flags.
- R8: Jump codes 7 to 15 raise `jmpFuncBad` and hold `branchTaken` low. Codes 0 to 6 keep `jmpFuncBad` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the flag register |
| opEn | input | 1 | Enables the flag load for this cycle's operation |
| aluFunc | input | 4 | Operation code |
| srcA | input | WIDTH | Source operand |
| srcB | input | WIDTH | Destination operand |
| jmpFunc | input | 4 | Jump condition code |
| result | output | WIDTH | Operation result |
| aluFuncBad | output | 1 | Operation code outside 0..3 |
| jmpFuncBad | output | 1 | Jump code outside 0..6 |
| branchTaken | output | 1 | Selected condition holds on the stored flags |
| flagOf | output | 1 | Stored overflow flag |
| flagZf | output | 1 | Stored zero flag |
| flagSf | output | 1 | Stored negative flag |

## Verification
The bench builds the block with its default 32-bit WIDTH. At this width, the sign-boundary operands 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF produce overflow in both directions for add and subtract, and a zero result through wraparound. Directed cycles set up each of the flag combinations a branch can depend on, and then sweep all sixteen jump codes against each one. Random cycles mix enabled, disabled and invalid operations, so that flag holding is exercised between loads.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;
  localparam int FUNC_W   = 4;
  localparam int NUM_OPS  = 4;
  localparam int NUM_JMPS = 7;

  typedef struct packed {
    logic [NUM_OPS-1:0]  aluSel;   // one-hot: add, sub, and, xor
    logic                flagWr;
    logic [NUM_JMPS-1:0] jmpSel;   // one-hot jump condition select
  } ctrlBus_t;
endpackage

// File: rtl/cond_alu_ctrl.sv
module cond_alu_ctrl
  import cond_alu_pkg::*;
(
  input  logic              opEn,
  input  logic [FUNC_W-1:0] aluFunc,
  input  logic [FUNC_W-1:0] jmpFunc,
  output ctrlBus_t          ctl,
  output logic              aluFuncBad,
  output logic              jmpFuncBad
);
  always_comb begin
    ctl = '0;
    aluFuncBad = 1'b1;
    if (aluFunc < FUNC_W'(NUM_OPS)) begin
      ctl.aluSel = NUM_OPS'(1) << aluFunc;
      aluFuncBad = 1'b0;
    end
    ctl.flagWr = opEn && !aluFuncBad;
    jmpFuncBad = 1'b1;
    if (jmpFunc < FUNC_W'(NUM_JMPS)) begin
      ctl.jmpSel = NUM_JMPS'(1) << jmpFunc;
      jmpFuncBad = 1'b0;
    end
  end
endmodule

// File: rtl/cond_alu_datapath.sv
module cond_alu_datapath
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlBus_t         ctl,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result,
  output logic             branchTaken,
  output logic             flagOf,
  output logic             flagZf,
  output logic             flagSf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sum, diff;
  logic ofAdd, ofSub, nextOf;
  logic less;
  logic [NUM_JMPS-1:0] condVec;

  assign sum  = srcB + srcA;
  assign diff = srcB - srcA;
  assign ofAdd = (srcA[MSB] == srcB[MSB]) && (sum[MSB] != srcB[MSB]);
  assign ofSub = (srcA[MSB] != srcB[MSB]) && (diff[MSB] != srcB[MSB]);

  always_comb begin
    result = '0;
    nextOf = 1'b0;
    if (ctl.aluSel[0]) begin result = sum;         nextOf = ofAdd; end
    if (ctl.aluSel[1]) begin result = diff;        nextOf = ofSub; end
    if (ctl.aluSel[2]) result = srcB & srcA;
    if (ctl.aluSel[3]) result = srcB ^ srcA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOf <= 1'b0;
      flagZf <= 1'b1;
      flagSf <= 1'b0;
    end else if (ctl.flagWr) begin
      flagOf <= nextOf;
      flagZf <= (result == '0);
      flagSf <= result[MSB];
    end
  end

  assign less = flagSf ^ flagOf;
  assign condVec = {!less && !flagZf, !less, !flagZf, flagZf, less, less || flagZf, 1'b1};
  assign branchTaken = |(condVec & ctl.jmpSel);

  // R2: flags hold when no load is strobed
  p_flags_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flagWr |=> ($stable(flagOf) && $stable(flagZf) && $stable(flagSf)));
  // R3: zero flag tracks the loaded result
  p_zero_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagWr |=> (flagZf == ($past(result) == '0)));
  // R3: negative flag tracks the loaded result sign
  p_sign_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagWr |=> (flagSf == $past(result[MSB])));
  // R4: logical operations clear overflow
  p_logic_of_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.flagWr && (ctl.aluSel[2] || ctl.aluSel[3])) |=> !flagOf);
endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opEn,
  input  logic [3:0]       aluFunc,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [3:0]       jmpFunc,
  output logic [WIDTH-1:0] result,
  output logic             aluFuncBad,
  output logic             jmpFuncBad,
  output logic             branchTaken,
  output logic             flagOf,
  output logic             flagZf,
  output logic             flagSf
);
  ctrlBus_t ctl;

  cond_alu_ctrl u_ctrl (
    .opEn(opEn), .aluFunc(aluFunc), .jmpFunc(jmpFunc),
    .ctl(ctl), .aluFuncBad(aluFuncBad), .jmpFuncBad(jmpFuncBad)
  );

  cond_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .srcA(srcA), .srcB(srcB),
    .result(result), .branchTaken(branchTaken),
    .flagOf(flagOf), .flagZf(flagZf), .flagSf(flagSf)
  );

  // R8: invalid jump code never reports taken
  p_bad_jump_not_taken_r8: assert property (@(posedge clk) disable iff (!rstN)
    jmpFuncBad |-> !branchTaken);
  // R6: unconditional jump always taken
  p_uncond_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (jmpFunc == 4'd0) |-> branchTaken);
  // R7: invalid operation code leaves flags alone even when enabled
  p_bad_op_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (aluFuncBad && opEn) |=> ($stable(flagOf) && $stable(flagZf) && $stable(flagSf)));
  // R7: invalid operation code yields zero result
  p_bad_op_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    aluFuncBad |-> (result == '0));
endmodule

// File: tb/cond_alu_tb.sv
module cond_alu_tb;
  localparam int WIDTH = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opEn = 1'b0;
  logic [3:0] aluFunc = '0;
  logic [3:0] jmpFunc = '0;
  logic [WIDTH-1:0] srcA = '0, srcB = '0;
  logic [WIDTH-1:0] result;
  logic aluFuncBad, jmpFuncBad, branchTaken, flagOf, flagZf, flagSf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference flag state
  bit mOf = 0, mZf = 1, mSf = 0;

  always #10 clk = ~clk;  // 50 MHz

  cond_alu #(.WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .opEn(opEn), .aluFunc(aluFunc), .srcA(srcA), .srcB(srcB),
    .jmpFunc(jmpFunc), .result(result), .aluFuncBad(aluFuncBad), .jmpFuncBad(jmpFuncBad),
    .branchTaken(branchTaken), .flagOf(flagOf), .flagZf(flagZf), .flagSf(flagSf)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit refBranch(int jf);
    bit l = mSf ^ mOf;
    case (jf)
      0: return 1'b1;
      1: return l | mZf;
      2: return l;
      3: return mZf;
      4: return !mZf;
      5: return !l;
      6: return !l && !mZf;
      default: return 1'b0;
    endcase
  endfunction

  // one cycle: drive, check combinational outputs and stored flags, then model the edge
  task automatic step(bit en, int af, longint unsigned a, longint unsigned b, int jf);
    longint unsigned mask = (64'd1 << WIDTH) - 1;
    longint unsigned r = 0;
    longint sa = $signed(a[WIDTH-1:0]);
    longint sb = $signed(b[WIDTH-1:0]);
    longint sr;
    bit of = 0;
    @(negedge clk);
    opEn = en; aluFunc = 4'(af); srcA = WIDTH'(a); srcB = WIDTH'(b); jmpFunc = 4'(jf);
    case (af)
      0: begin r = (b + a) & mask; sr = sb + sa; end
      1: begin r = (b - a) & mask; sr = sb - sa; end
      2: begin r = b & a & mask; sr = 0; end
      3: begin r = (b ^ a) & mask; sr = 0; end
      default: begin r = 0; sr = 0; end
    endcase
    if (af < 2) of = (sr > longint'(2 ** (WIDTH - 1)) - 1) || (sr < -longint'(2 ** (WIDTH - 1)));
    #3;
    check(af < 4 ? "R1" : "R7", "result", longint'(result), longint'(r));
    check("R7", "aluFuncBad", aluFuncBad, af >= 4);
    check("R8", "jmpFuncBad", jmpFuncBad, jf >= 7);
    check(jf < 7 ? "R6" : "R8", "branchTaken", branchTaken, refBranch(jf));
    check("R2/R3/R4", "flags", {flagOf, flagZf, flagSf}, {mOf, mZf, mSf});
    @(posedge clk);
    if (en && af < 4) begin  // R2 load condition
      mOf = of;
      mZf = (r == 0);
      mSf = r[WIDTH-1];
    end
  endtask

  task automatic sweepJumps();
    for (int j = 0; j < 16; j++) step(1'b0, 0, 0, 0, j);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R5", "reset flags", {flagOf, flagZf, flagSf}, 3'b010);
    @(negedge clk);
    rstN = 1'b1;
    sweepJumps();                                       // R6 with ZF only
    step(1, 0, 64'h1, 64'h7FFFFFFF, 0);                 // R4 add overflow, negative
    sweepJumps();
    step(1, 1, 64'h1, 64'h80000000, 0);                 // R4 sub overflow, positive
    sweepJumps();
    step(1, 1, 64'h5, 64'h3, 0);                        // R1 negative, no overflow
    sweepJumps();
    step(1, 0, 64'h1, 64'hFFFFFFFF, 0);                 // R3 wrap to zero
    step(0, 2, 64'hF0F0F0F0, 64'hFFFF0000, 0);          // R2 disabled, flags hold
    sweepJumps();
    step(1, 1, 64'h7FFFFFFF, 64'hFFFFFFFF, 0);          // R4 sub, no overflow
    step(1, 2, 64'hF0F0F0F0, 64'hFFFF0000, 0);          // R4 AND clears overflow
    step(1, 3, 64'h12345678, 64'h12345678, 0);          // R3 XOR zero
    step(1, 9, 64'h1, 64'h80000000, 3);                 // R7 invalid op, flags hold
    step(1, 15, 64'h0, 64'h0, 15);                      // R7 / R8
    step(1, 1, 64'h80000000, 64'h0, 0);                 // R4 0 - min overflows
    sweepJumps();
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom, b = $urandom, ctl = $urandom;
      if (ctl[8]) a = {ctl[9], 31'h0};
      if (ctl[10]) b = a;
      step(ctl[0] | ctl[1], ctl[3] ? int'(ctl[7:4]) : int'(ctl[5:4]), a, b, int'(ctl[15:12]));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule